// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block manages the low-power state of a small 8-bit microcontroller core. When the core executes its sleep instruction it raises a one-cycle sleep request. The sequencer then gates off the instruction clock and watches three wake causes:

- an external reset request,
- a watchdog timeout, which counts only while the watchdog is enabled,
- any interrupt flag whose individual enable is set.

On a wake it clears the watchdog. It then holds the clock off for an oscillator start-up interval. After that it restarts the clock and gives the core exactly one instruction: resume in-line, take the interrupt vector, or reset.

The global interrupt enable does not gate waking. It decides only whether an interrupt wake is followed by a vector pulse. A vector pulse comes one instruction cycle (four oscillator periods) after the resume pulse, which leaves room for the prefetched instruction and a dummy cycle.

A sleep request made while an enabled flag is already set never stops the clock. It acts as a no-op that still updates the status bits. The block also keeps two status bits: a power-down bit and a timeout bit.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset (rstN low), clkRun=1, statusPd=1, statusTo=1, and resumePulse, vectorPulse, coreReset and wdtClear are all 0.
- R2: A sleepReq pulse with no pending enabled flag has these effects. clkRun is 0 from the cycle after the request edge. statusPd is cleared in that cycle and statusTo is set.
- R3: While asleep, these produce no wake, no wdtClear and no resume, and clkRun stays 0:
  - flags whose enable bit is 0,
  - wdtTimeout while wdtEnable=0.
- R4: An interrupt wake starts when any bit of (intFlags AND intEnables) is set while asleep. The source is sampled through two flops, and the wake responds as follows:
  - wdtClear is high for one cycle, starting 3 edges after the source is applied.
  - After a further OST_CYCLES edges, clkRun returns to 1 and resumePulse is high for one cycle.
- R5: After an interrupt wake, vectorPulse is high for one cycle exactly 4 cycles after resumePulse when gie is 1 at resume time. No vectorPulse follows when gie is 0.
- R6: A watchdog wake (wdtTimeout with wdtEnable=1) follows the R4 timing. It clears statusTo in the wdtClear cycle and is never followed by vectorPulse, even with gie=1.
- R7: An external reset wake (extResetReq) follows the R4 timing, but it drives a one-cycle coreReset instead of resumePulse. It is followed by no vectorPulse, and leaves statusPd=0 and statusTo=1.
- R8: If an external reset and an interrupt wake arrive in the same cycle, the reset wins. The outcome is exactly that of R7.
- R9: A sleepReq made while some enabled flag is set never stops the clock. In the cycle after the request edge, resumePulse and wdtClear are 1 and statusPd is 0. With gie=1, vectorPulse follows 4 cycles after resumePulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| sleepReq | input | 1 | One-cycle pulse when the core executes sleep |
| gie | input | 1 | Global interrupt enable from the core |
| wdtEnable | input | 1 | Watchdog enabled |
| wdtTimeout | input | 1 | Watchdog timeout event (asynchronous) |
| extResetReq | input | 1 | External reset pin request, active high (asynchronous) |
| intFlags | input | N_IRQ | Interrupt flags (asynchronous) |
| intEnables | input | N_IRQ | Per-source interrupt enables |
| clkRun | output | 1 | Instruction clock enable |
| resumePulse | output | 1 | Core continues at the next instruction |
| vectorPulse | output | 1 | Core branches to the interrupt vector |
| coreReset | output | 1 | Core reset after an external reset wake |
| wdtClear | output | 1 | Clears the watchdog counter |
| statusTo | output | 1 | Timeout status bit |
| statusPd | output | 1 | Power-down status bit |

## Verification
The bench measures the exact edge count from a wake source to wdtClear, to resume and to vector. Any change to the synchroniser depth or to the start-up count therefore shows up as a wrong latency. It pits masked flags and a disabled watchdog against a sleeping block. A design that ignored an enable would wake and pulse resume. It also fires reset and interrupt in the same cycle, where a wrong priority would show as a resume or vector pulse instead of coreReset. A sleep with a flag already pending must resume one cycle later with the clock never stopping. A design that slept anyway would wait out the whole start-up interval.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int Q_PHASES = 4;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_ASLEEP  = 2'd1,
    ST_STARTUP = 2'd2,
    ST_VECWAIT = 2'd3
  } swcState_t;

  typedef enum logic [1:0] {
    CAUSE_INT = 2'd0,
    CAUSE_WDT = 2'd1,
    CAUSE_RST = 2'd2
  } swcCause_t;

  typedef struct packed {
    logic sleepEnter;
    logic clearTo;
    logic clearWdt;
    logic loadOst;
    logic loadVec;
    logic fireResume;
    logic fireReset;
    logic fireVector;
  } swcStrobes_t;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        gie,
  input  logic        pendingNow,
  input  logic        rstWake,
  input  logic        wdtWake,
  input  logic        intWake,
  input  logic        ostDone,
  input  logic        vecDone,
  output swcStrobes_t strb,
  output logic        clkRun
);
  swcState_t state, stateNext;
  swcCause_t cause, causeNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    causeNext = cause;
    case (state)
      ST_RUN: begin
        if (sleepReq) begin
          strb.sleepEnter = 1'b1;
          if (pendingNow) begin
            strb.clearWdt   = 1'b1;
            strb.fireResume = 1'b1;
            if (gie) begin
              strb.loadVec = 1'b1;
              stateNext    = ST_VECWAIT;
            end
          end else begin
            stateNext = ST_ASLEEP;
          end
        end
      end
      ST_ASLEEP: begin
        if (rstWake || wdtWake || intWake) begin
          strb.clearWdt = 1'b1;
          strb.loadOst  = 1'b1;
          stateNext     = ST_STARTUP;
          if (rstWake) begin
            causeNext = CAUSE_RST;
          end else if (wdtWake) begin
            causeNext    = CAUSE_WDT;
            strb.clearTo = 1'b1;
          end else begin
            causeNext = CAUSE_INT;
          end
        end
      end
      ST_STARTUP: begin
        if (ostDone) begin
          stateNext = ST_RUN;
          if (cause == CAUSE_RST) begin
            strb.fireReset = 1'b1;
          end else begin
            strb.fireResume = 1'b1;
            if (cause == CAUSE_INT && gie) begin
              strb.loadVec = 1'b1;
              stateNext    = ST_VECWAIT;
            end
          end
        end
      end
      ST_VECWAIT: begin
        if (vecDone) begin
          strb.fireVector = 1'b1;
          stateNext       = ST_RUN;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      cause <= CAUSE_INT;
    end else begin
      state <= stateNext;
      cause <= causeNext;
    end
  end

  assign clkRun = (state == ST_RUN) || (state == ST_VECWAIT);
endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  swcStrobes_t strb,
  output logic        ostDone,
  output logic        vecDone,
  output logic        resumePulse,
  output logic        vectorPulse,
  output logic        coreReset,
  output logic        wdtClear,
  output logic        statusTo,
  output logic        statusPd
);
  localparam int OST_W = (OST_CYCLES > 2) ? $clog2(OST_CYCLES) : 1;
  localparam int VEC_W = $clog2(Q_PHASES);
  localparam logic [OST_W-1:0] OST_LOAD = OST_W'(OST_CYCLES - 1);
  localparam logic [VEC_W-1:0] VEC_LOAD = VEC_W'(Q_PHASES - 1);

  logic [OST_W-1:0] ostCount;
  logic [VEC_W-1:0] vecCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ostCount <= '0;
    end else if (strb.loadOst) begin
      ostCount <= OST_LOAD;
    end else if (ostCount != '0) begin
      ostCount <= ostCount - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecCount <= '0;
    end else if (strb.loadVec) begin
      vecCount <= VEC_LOAD;
    end else if (vecCount != '0) begin
      vecCount <= vecCount - 1'b1;
    end
  end

  assign ostDone = (ostCount == '0);
  assign vecDone = (vecCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusPd <= 1'b1;
      statusTo <= 1'b1;
    end else begin
      if (strb.sleepEnter) begin
        statusPd <= 1'b0;
        statusTo <= 1'b1;
      end else if (strb.clearTo) begin
        statusTo <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumePulse <= 1'b0;
      vectorPulse <= 1'b0;
      coreReset   <= 1'b0;
      wdtClear    <= 1'b0;
    end else begin
      resumePulse <= strb.fireResume;
      vectorPulse <= strb.fireVector;
      coreReset   <= strb.fireReset;
      wdtClear    <= strb.clearWdt;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int OST_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             gie,
  input  logic             wdtEnable,
  input  logic             wdtTimeout,
  input  logic             extResetReq,
  input  logic [N_IRQ-1:0] intFlags,
  input  logic [N_IRQ-1:0] intEnables,
  output logic             clkRun,
  output logic             resumePulse,
  output logic             vectorPulse,
  output logic             coreReset,
  output logic             wdtClear,
  output logic             statusTo,
  output logic             statusPd
);
  localparam int N_SRC = 3;

  logic             pendingNow;
  logic [N_SRC-1:0] rawSrc;
  logic [N_SRC-1:0] syncSrc;
  logic             ostDone;
  logic             vecDone;
  swcStrobes_t      strb;

  assign pendingNow = |(intFlags & intEnables);
  assign rawSrc     = {extResetReq, wdtTimeout & wdtEnable, pendingNow};

  swc_sync #(.WIDTH(N_SRC)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawSrc),
    .syncOut (syncSrc)
  );

  swc_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .gie        (gie),
    .pendingNow (pendingNow),
    .rstWake    (syncSrc[2]),
    .wdtWake    (syncSrc[1]),
    .intWake    (syncSrc[0]),
    .ostDone    (ostDone),
    .vecDone    (vecDone),
    .strb       (strb),
    .clkRun     (clkRun)
  );

  swc_datapath #(.OST_CYCLES(OST_CYCLES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .ostDone     (ostDone),
    .vecDone     (vecDone),
    .resumePulse (resumePulse),
    .vectorPulse (vectorPulse),
    .coreReset   (coreReset),
    .wdtClear    (wdtClear),
    .statusTo    (statusTo),
    .statusPd    (statusPd)
  );
endmodule

// File: rtl/swc_checker.sv
module swc_checker (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic clkRun,
  input logic resumePulse,
  input logic vectorPulse,
  input logic coreReset,
  input logic wdtClear,
  input logic statusTo,
  input logic statusPd
);
  a_r2_pd_falls_on_sleep: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusPd) |-> $past(sleepReq));

  a_r4_resume_single: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |=> !resumePulse);

  a_r4_resume_clock_on: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> clkRun);

  a_r5_vector_after_resume: assert property (@(posedge clk) disable iff (!rstN)
    vectorPulse |-> $past(resumePulse, 4));

  a_r6_to_falls_on_wdt_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusTo) |-> wdtClear);

  a_r7_reset_excludes_resume: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |-> !resumePulse && !vectorPulse);

  a_r7_reset_single: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |=> !coreReset);
endmodule

bind sleep_wake_ctrl swc_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sleepReq    (sleepReq),
  .clkRun      (clkRun),
  .resumePulse (resumePulse),
  .vectorPulse (vectorPulse),
  .coreReset   (coreReset),
  .wdtClear    (wdtClear),
  .statusTo    (statusTo),
  .statusPd    (statusPd)
);

// File: tb/sim_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_wake_ctrl;
  localparam int N_IRQ = 8;
  localparam int OST   = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0, gie = 1'b0, wdtEnable = 1'b0, wdtTimeout = 1'b0, extResetReq = 1'b0;
  logic [N_IRQ-1:0] intFlags = '0, intEnables = '0;
  logic clkRun, resumePulse, vectorPulse, coreReset, wdtClear, statusTo, statusPd;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(N_IRQ), .OST_CYCLES(OST)) u0 (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .gie(gie), .wdtEnable(wdtEnable),
    .wdtTimeout(wdtTimeout), .extResetReq(extResetReq), .intFlags(intFlags),
    .intEnables(intEnables), .clkRun(clkRun), .resumePulse(resumePulse),
    .vectorPulse(vectorPulse), .coreReset(coreReset), .wdtClear(wdtClear),
    .statusTo(statusTo), .statusPd(statusPd)
  );

  // kind: 0 interrupt, 1 watchdog, 2 external reset, 3 reset+interrupt
  typedef struct packed {
    logic [1:0] kind;
    logic       g;
    logic [7:0] fl;
    logic [7:0] en;
    logic       expRes;
    logic       expRst;
    logic       expVec;
    logic       expTo;
  } vec_t;

  localparam vec_t TABLE [0:5] = '{
    '{2'd0, 1'b0, 8'h01, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'd0, 1'b1, 8'h04, 8'h04, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd3, 1'b1, 8'h10, 8'h10, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd0, 1'b0, 8'h80, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Pulses sleepReq; returns at the negedge after the request edge.
  task automatic sleepPulse();
    @(negedge clk);
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
  endtask

  task automatic runRow(input int idx);
    vec_t v;
    int tClr, tRes, tRst, tVec;
    int runBefore, runAfter;
    string tag;
    v = TABLE[idx];
    case (v.kind)
      2'd0: tag = v.g ? "R5" : "R4";
      2'd1: tag = "R6";
      2'd2: tag = "R7";
      default: tag = "R8";
    endcase
    gie = v.g;
    wdtEnable = (v.kind == 2'd1);
    sleepPulse();
    chk(clkRun == 1'b0, "R2 clock stops", int'(clkRun), 0);
    chk(statusPd == 1'b0 && statusTo == 1'b1, "R2 status on sleep",
        int'({statusPd, statusTo}), 1);
    repeat (4) @(negedge clk);
    if (v.kind == 2'd1) wdtTimeout = 1'b1;
    if (v.kind[1]) extResetReq = 1'b1;
    intFlags = v.fl;
    intEnables = v.en;
    tClr = -1; tRes = -1; tRst = -1; tVec = -1; runBefore = -1; runAfter = -1;
    for (int k = 1; k <= OST + 12; k++) begin
      @(negedge clk);
      if (wdtClear && tClr < 0) tClr = k;
      if (resumePulse && tRes < 0) tRes = k;
      if (coreReset && tRst < 0) tRst = k;
      if (vectorPulse && tVec < 0) tVec = k;
      if (k == OST + 2) runBefore = int'(clkRun);
      if (k == OST + 3) runAfter = int'(clkRun);
      if (k == 3) begin
        wdtTimeout = 1'b0;
        extResetReq = 1'b0;
        intFlags = '0;
      end
    end
    chk(tClr == 3, {tag, " wdtClear latency"}, tClr, 3);
    chk(tRes == (v.expRes ? OST + 3 : -1), {tag, " resume timing"}, tRes, v.expRes ? OST + 3 : -1);
    chk(tRst == (v.expRst ? OST + 3 : -1), {tag, " coreReset timing"}, tRst, v.expRst ? OST + 3 : -1);
    chk(tVec == (v.expVec ? OST + 7 : -1), {tag, " vector timing"}, tVec, v.expVec ? OST + 7 : -1);
    chk(runBefore == 0 && runAfter == 1, {tag, " clock restart"}, runBefore * 2 + runAfter, 1);
    chk(statusTo == v.expTo && statusPd == 1'b0, {tag, " status after wake"},
        int'({statusPd, statusTo}), int'({1'b0, v.expTo}));
    intEnables = '0;
    wdtEnable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int tRes, tVec, tClr;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(clkRun == 1'b1, "R1 clkRun", int'(clkRun), 1);
    chk(statusPd == 1'b1 && statusTo == 1'b1, "R1 status", int'({statusPd, statusTo}), 3);
    chk({resumePulse, vectorPulse, coreReset, wdtClear} == 4'b0, "R1 pulses",
        int'({resumePulse, vectorPulse, coreReset, wdtClear}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(clkRun == 1'b1 && statusPd == 1'b1, "R1 after release", int'({clkRun, statusPd}), 3);

    for (int i = 0; i < 6; i++) runRow(i);

    // R3: masked flags and a disabled watchdog do not wake
    gie = 1'b1;
    sleepPulse();
    intFlags = 8'hFF;
    intEnables = 8'h00;
    wdtEnable = 1'b0;
    wdtTimeout = 1'b1;
    tClr = -1; tRes = -1;
    for (int k = 1; k <= 120; k++) begin
      @(negedge clk);
      if (wdtClear && tClr < 0) tClr = k;
      if (resumePulse && tRes < 0) tRes = k;
    end
    chk(clkRun == 1'b0, "R3 clock stays off", int'(clkRun), 0);
    chk(tClr == -1 && tRes == -1, "R3 no wake", tClr, -1);
    wdtTimeout = 1'b0;
    intFlags = 8'h20;
    intEnables = 8'h20;
    tRes = -1;
    for (int k = 1; k <= OST + 8; k++) begin
      @(negedge clk);
      if (resumePulse && tRes < 0) tRes = k;
      if (k == 3) intFlags = '0;
    end
    chk(tRes == OST + 3, "R4 wake after masked period", tRes, OST + 3);
    intEnables = '0;
    repeat (6) @(negedge clk);

    // R9: pending flag at sleep, gie=1
    gie = 1'b1;
    intFlags = 8'h02;
    intEnables = 8'h02;
    sleepPulse();
    chk(resumePulse && wdtClear && clkRun, "R9 immediate resume",
        int'({resumePulse, wdtClear, clkRun}), 7);
    chk(statusPd == 1'b0, "R9 pd cleared", int'(statusPd), 0);
    tVec = -1;
    for (int k = 2; k <= 10; k++) begin
      @(negedge clk);
      if (vectorPulse && tVec < 0) tVec = k;
    end
    chk(tVec == 5, "R9 vector after immediate resume", tVec, 5);

    // R9: pending flag at sleep, gie=0
    gie = 1'b0;
    sleepPulse();
    chk(resumePulse && clkRun, "R9 immediate resume gie0", int'({resumePulse, clkRun}), 3);
    tVec = -1;
    for (int k = 2; k <= 10; k++) begin
      @(negedge clk);
      if (vectorPulse && tVec < 0) tVec = k;
    end
    chk(tVec == -1, "R9 no vector gie0", tVec, -1);
    intFlags = '0;
    intEnables = '0;

    summary();
  end
endmodule